// File: doc/BRIEF.md
# Multi-Mode TDM Frame Timing Generator

This block derives the complete bit, timeslot, frame and multiframe timing for two time-division-multiplexed buses from a single bit clock. One bus, the expansion bus, supports frames of 193, 256, 512 or 1024 bits. The other, the local bus, supports only a 193-bit frame or a 256-bit frame. A 2-bit framing-mode input picks the frame format for both buses at once. A single bus-mode input says whether the expansion bus carries a multiframe sync.

For each bus the block reports four things: the position of the current bit in the frame, the current timeslot, the current frame within the multiframe, and one-cycle frame-sync and multiframe-sync strobes. Each bus takes a new framing mode only at its own next frame boundary, so a frame in progress is never cut short. A combinational flag marks framing and bus mode pairs that are not legal. Counting goes on with the table entry for the selected code even while the flag is set.

Top module: `tdm_frame_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it, both buses are at bit 0, timeslot 0 and frame 0, and the active framing code is 00.
- R2: On the expansion bus, the frame length is 193 bits for framing code 00, 256 for code 01, 512 for code 10 and 1024 for code 11. The bit counter counts up from 0 to the length minus 1 and then returns to 0.
- R3: On the local bus, the frame length is 193 bits for framing code 00 and 256 bits for every other code.
- R4: With a 193-bit frame, bit 0 is a framing bit and the timeslot output stays at 0 during it. Bits 1 to 192 form 24 eight-bit timeslots, so the timeslot is (bit-1)/8. With any longer frame, the timeslot is bit/8.
- R5: Frame sync on each bus is high for exactly the cycle in which that bus's bit counter is 0.
- R6: The frame index counts frames within a multiframe. A multiframe is 12 frames long with a 193-bit frame and 16 frames long otherwise. Multiframe sync is high only when both the bit counter and the frame index are 0.
- R7: When bus_mode is 0, the expansion multiframe sync output stays low. The expansion frame index keeps free-running in step with frame sync. When bus_mode is 1, the expansion multiframe sync follows R6. The local multiframe sync always follows R6.
- R8: mode_invalid is 1 in two cases: bus_mode is 0 and the framing code is 00, or bus_mode is 1 and the framing code is 10 or 11. It is 0 otherwise.
- R9: A change of framing code takes effect on a bus only in the cycle in which that bus's bit counter wraps to 0. At that wrap, the frame index returns to 0 if it is already at or beyond the last frame of the new multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mode | input | 2 | Requested framing code |
| bus_mode | input | 1 | 1 = expansion bus carries multiframe sync |
| exp_bit_cnt | output | 10 | Expansion bit within frame |
| exp_slot | output | 7 | Expansion timeslot index |
| exp_frame | output | 4 | Expansion frame within multiframe |
| exp_fsync | output | 1 | Expansion frame-sync strobe |
| exp_msync | output | 1 | Expansion multiframe-sync strobe |
| loc_bit_cnt | output | 8 | Local bit within frame |
| loc_slot | output | 5 | Local timeslot index |
| loc_frame | output | 4 | Local frame within multiframe |
| loc_fsync | output | 1 | Local frame-sync strobe |
| loc_msync | output | 1 | Local multiframe-sync strobe |
| mode_invalid | output | 1 | Illegal framing/bus mode pair |

## Verification
The bench steps through all eight pairs of bus mode and framing code. Each pair is held for a full expansion multiframe plus a tail, and a cycle-by-cycle arithmetic model is compared on every cycle. Codes 10 and 11 show the local-bus clamp apart from the expansion-bus lengths, and code 00 checks the framing-bit offset and the 12-frame multiframe. Because each pair runs for a length that is not a whole number of frames, every code change arrives in the middle of a frame, so a change at the frame boundary can be told apart from an immediate one. The bus_mode 0 passes show that the expansion multiframe sync is gated while its frame index keeps running.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;

    localparam int FRAME_W = 4;

    // Frame length in bits for a framing code.
    function automatic int frame_bits(input int code);
        return (code == 0) ? 193 : (128 << code);
    endfunction

    // Frames in one multiframe for a framing code.
    function automatic int frames_per_mf(input int code);
        return (code == 0) ? 12 : 16;
    endfunction

    // Timeslots in one frame for a framing code.
    function automatic int slots_per_frame(input int code);
        return (code == 0) ? 24 : (frame_bits(code) / 8);
    endfunction

    // Counter width that covers the longest frame of a bus.
    function automatic int bit_width(input int max_code);
        return $clog2(frame_bits(max_code));
    endfunction

    // Timeslot seen at a given bit; the 193-bit framing bit maps to 0.
    function automatic int slot_of(input int code, input int bit_idx);
        if (code == 0)
            return (bit_idx == 0) ? 0 : (bit_idx - 1) / 8;
        return bit_idx / 8;
    endfunction

endpackage

// File: rtl/tdm_mode_check.sv
module tdm_mode_check (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_mode,
    input  logic [1:0] frame_mode,
    output logic       invalid
);

    logic bad_no_mf;
    logic bad_with_mf;

    always_comb begin
        bad_no_mf   = !bus_mode && (frame_mode == 2'b00);
        bad_with_mf = bus_mode && frame_mode[1];
        invalid     = bad_no_mf | bad_with_mf;
    end

    p_legal_pairs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode && !frame_mode[1]) || (!bus_mode && frame_mode != 2'b00) |-> !invalid)
        else $error("p_legal_pairs_r8");

endmodule

// File: rtl/tdm_bus_counter.sv
module tdm_bus_counter
    import tdm_timing_pkg::*;
#(
    parameter  int MAX_CODE = 3,
    localparam int BW       = bit_width(MAX_CODE),
    localparam int SW       = BW - 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_req,
    output logic [BW-1:0]      bit_cnt,
    output logic [SW-1:0]      slot,
    output logic [FRAME_W-1:0] frame,
    output logic               fsync,
    output logic               msync
);

    typedef struct packed {
        logic [1:0]         mode;
        logic [BW-1:0]      bits;
        logic [SW-1:0]      slot;
        logic [FRAME_W-1:0] frame;
    } bus_state_t;

    bus_state_t st_d, st_q;
    logic [1:0] code_eff;
    logic       last_bit;

    // Codes beyond what this bus supports fall back to its largest frame.
    generate
        if (MAX_CODE >= 3) begin : g_full_range
            assign code_eff = mode_req;
        end else begin : g_clamped
            assign code_eff = (int'(mode_req) > MAX_CODE) ? 2'(MAX_CODE) : mode_req;
        end
    endgenerate

    assign last_bit = (int'(st_q.bits) == frame_bits(int'(st_q.mode)) - 1);

    always_comb begin
        st_d = st_q;
        if (last_bit) begin
            st_d.mode = code_eff;
            st_d.bits = '0;
            if (int'(st_q.frame) >= frames_per_mf(int'(code_eff)) - 1)
                st_d.frame = '0;
            else
                st_d.frame = st_q.frame + 1'b1;
        end else begin
            st_d.bits = st_q.bits + 1'b1;
        end
        st_d.slot = SW'(slot_of(int'(st_d.mode), int'(st_d.bits)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bit_cnt = st_q.bits;
    assign slot    = st_q.slot;
    assign frame   = st_q.frame;
    assign fsync   = (st_q.bits == '0);
    assign msync   = fsync && (st_q.frame == '0);

    p_bit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !last_bit |=> bit_cnt == $past(bit_cnt) + 1'b1)
        else $error("p_bit_step_r2");

    p_bit_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_bit |=> bit_cnt == '0)
        else $error("p_bit_wrap_r2");

    p_slot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(slot) < slots_per_frame(int'(st_q.mode)))
        else $error("p_slot_bound_r4");

    p_msync_in_fsync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        msync |-> fsync)
        else $error("p_msync_in_fsync_r6");

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !last_bit |=> $stable(st_q.mode))
        else $error("p_mode_hold_r9");

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_timing_pkg::*;
#(
    parameter  int EXP_MAX_CODE = 3,
    parameter  int LOC_MAX_CODE = 1,
    localparam int EXP_BW       = bit_width(EXP_MAX_CODE),
    localparam int LOC_BW       = bit_width(LOC_MAX_CODE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         frame_mode,
    input  logic               bus_mode,
    output logic [EXP_BW-1:0]  exp_bit_cnt,
    output logic [EXP_BW-4:0]  exp_slot,
    output logic [FRAME_W-1:0] exp_frame,
    output logic               exp_fsync,
    output logic               exp_msync,
    output logic [LOC_BW-1:0]  loc_bit_cnt,
    output logic [LOC_BW-4:0]  loc_slot,
    output logic [FRAME_W-1:0] loc_frame,
    output logic               loc_fsync,
    output logic               loc_msync,
    output logic               mode_invalid
);

    logic exp_msync_int;

    tdm_bus_counter #(.MAX_CODE(EXP_MAX_CODE)) u_exp (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (frame_mode),
        .bit_cnt  (exp_bit_cnt),
        .slot     (exp_slot),
        .frame    (exp_frame),
        .fsync    (exp_fsync),
        .msync    (exp_msync_int)
    );

    tdm_bus_counter #(.MAX_CODE(LOC_MAX_CODE)) u_loc (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (frame_mode),
        .bit_cnt  (loc_bit_cnt),
        .slot     (loc_slot),
        .frame    (loc_frame),
        .fsync    (loc_fsync),
        .msync    (loc_msync)
    );

    tdm_mode_check u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_mode   (bus_mode),
        .frame_mode (frame_mode),
        .invalid    (mode_invalid)
    );

    // The internal multiframe keeps running; only the pin is suppressed.
    assign exp_msync = exp_msync_int & bus_mode;

    p_exp_msync_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_mode |-> !exp_msync)
        else $error("p_exp_msync_off_r7");

    p_fsync_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_mode == 2'b00 && exp_fsync && loc_fsync) |=> (exp_fsync == loc_fsync))
        else $error("p_fsync_aligned_r5");

endmodule

// File: tb/tdm_frame_timer_test.sv
module tdm_frame_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] frame_mode = 2'b00;
    logic       bus_mode = 1'b0;

    logic [9:0] exp_bit_cnt;
    logic [6:0] exp_slot;
    logic [3:0] exp_frame;
    logic       exp_fsync, exp_msync;
    logic [7:0] loc_bit_cnt;
    logic [4:0] loc_slot;
    logic [3:0] loc_frame;
    logic       loc_fsync, loc_msync;
    logic       mode_invalid;

    int n_chk = 0;
    int n_bad = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    // Arithmetic model state
    int me_mode = 0, me_bit = 0, me_frame = 0;
    int ml_mode = 0, ml_bit = 0, ml_frame = 0;

    always #10 clk = ~clk;

    tdm_frame_timer uut (
        .clk(clk), .rst_n(rst_n), .frame_mode(frame_mode), .bus_mode(bus_mode),
        .exp_bit_cnt(exp_bit_cnt), .exp_slot(exp_slot), .exp_frame(exp_frame),
        .exp_fsync(exp_fsync), .exp_msync(exp_msync),
        .loc_bit_cnt(loc_bit_cnt), .loc_slot(loc_slot), .loc_frame(loc_frame),
        .loc_fsync(loc_fsync), .loc_msync(loc_msync), .mode_invalid(mode_invalid)
    );

    function automatic int m_len(input int c);
        return (c == 0) ? 193 : (128 << c);
    endfunction

    function automatic int m_mf(input int c);
        return (c == 0) ? 12 : 16;
    endfunction

    function automatic int m_slot(input int c, input int b);
        if (c == 0) return (b == 0) ? 0 : (b - 1) / 8;
        return b / 8;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            me_mode <= 0; me_bit <= 0; me_frame <= 0;
            ml_mode <= 0; ml_bit <= 0; ml_frame <= 0;
        end else begin
            if (me_bit == m_len(me_mode) - 1) begin
                me_mode  <= int'(frame_mode);
                me_bit   <= 0;
                me_frame <= (me_frame >= m_mf(int'(frame_mode)) - 1) ? 0 : me_frame + 1;
            end else begin
                me_bit <= me_bit + 1;
            end
            if (ml_bit == m_len(ml_mode) - 1) begin
                ml_mode  <= (frame_mode == 2'b00) ? 0 : 1;
                ml_bit   <= 0;
                ml_frame <= (ml_frame >= m_mf((frame_mode == 2'b00) ? 0 : 1) - 1) ? 0 : ml_frame + 1;
            end else begin
                ml_bit <= ml_bit + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            int inv;
            inv = ((!bus_mode && frame_mode == 2'b00) || (bus_mode && frame_mode[1])) ? 1 : 0;
            chk(int'(exp_bit_cnt) == me_bit, "R2,R9", "exp_bit_cnt", int'(exp_bit_cnt), me_bit);
            chk(int'(loc_bit_cnt) == ml_bit, "R3,R9", "loc_bit_cnt", int'(loc_bit_cnt), ml_bit);
            chk(int'(exp_slot) == m_slot(me_mode, me_bit), "R4", "exp_slot",
                int'(exp_slot), m_slot(me_mode, me_bit));
            chk(int'(loc_slot) == m_slot(ml_mode, ml_bit), "R4", "loc_slot",
                int'(loc_slot), m_slot(ml_mode, ml_bit));
            chk(exp_fsync == (me_bit == 0), "R5", "exp_fsync", int'(exp_fsync), int'(me_bit == 0));
            chk(loc_fsync == (ml_bit == 0), "R5", "loc_fsync", int'(loc_fsync), int'(ml_bit == 0));
            chk(int'(exp_frame) == me_frame, "R6,R7", "exp_frame", int'(exp_frame), me_frame);
            chk(int'(loc_frame) == ml_frame, "R6", "loc_frame", int'(loc_frame), ml_frame);
            chk(exp_msync == (bus_mode && me_bit == 0 && me_frame == 0), "R7", "exp_msync",
                int'(exp_msync), int'(bus_mode && me_bit == 0 && me_frame == 0));
            chk(loc_msync == (ml_bit == 0 && ml_frame == 0), "R6", "loc_msync",
                int'(loc_msync), int'(ml_bit == 0 && ml_frame == 0));
            chk(int'(mode_invalid) == inv, "R8", "mode_invalid", int'(mode_invalid), inv);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 200000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: state held in reset
        repeat (3) @(negedge clk);
        chk(exp_bit_cnt == '0, "R1", "exp_bit_cnt in reset", int'(exp_bit_cnt), 0);
        chk(loc_bit_cnt == '0, "R1", "loc_bit_cnt in reset", int'(loc_bit_cnt), 0);
        chk(exp_slot == '0 && loc_slot == '0, "R1", "slots in reset",
            int'(exp_slot) + int'(loc_slot), 0);
        chk(exp_frame == '0 && loc_frame == '0, "R1", "frames in reset",
            int'(exp_frame) + int'(loc_frame), 0);
        chk(mode_invalid == 1'b1, "R8", "invalid for no-mf code 00", int'(mode_invalid), 1);

        @(posedge clk); #2;
        rst_n = 1'b1;
        checking = 1'b1;
        @(negedge clk);
        chk(exp_bit_cnt == '0 && loc_bit_cnt == '0, "R1", "first cycle after reset",
            int'(exp_bit_cnt) + int'(loc_bit_cnt), 0);

        for (int bm = 0; bm < 2; bm++) begin
            for (int fm = 0; fm < 4; fm++) begin
                @(posedge clk); #2;
                bus_mode   = bm[0];
                frame_mode = fm[1:0];
                repeat (m_len(fm) * m_mf(fm) + 211) @(posedge clk);
            end
        end

        @(negedge clk);
        checking = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule